// File: doc/BRIEF.md
# Strap-Configured Management Register Target

This block is the register front end that a multi-port device presents on a shared management bus. It receives one already-decoded bus transaction at a time: a valid strobe, a read/write flag, a 5-bit bus address, a 5-bit register number and 16 bits of write data. It compares the bus address with a set of strap pins and decides whether the transaction belongs to this device. If it does, the block forwards the transaction to an internal register file that holds 32 sub-devices of 32 registers each.

The straps select one of three windows. In the shared single-device window every bus address maps straight onto the sub-device with the same number. In the half-space window, one strap picks the lower or upper 16 bus addresses, and bus address base+n reaches sub-device n. In the indirect window the device answers only at its own even bus address and shows only two registers, a command word and a data word. A command carries a sub-device and register number, an access kind and a start/busy flag. The internal access runs for a fixed number of cycles, and the busy flag clears by itself when it finishes.

Every owned transaction is answered one cycle later on a registered response port. Transactions this device does not own produce no response.

Top module: `strap_smi_target`

## Requirements
- R1: The own bus address is {strap[3:0], 0}: bit 0 is always zero. In the indirect window only that address is answered, and odd addresses are never answered.
- R2: With `dual_strap`=0 and `strap`=0, every bus address is answered, and bus address a with register r reads or writes sub-device a, register r directly.
- R3: In the indirect window, register 0 (command) and register 1 (data) at the own address are the only ones answered. Other registers at that address, and all other addresses, give no response and cause no internal access.
- R4: The command word fields are: bit 15 start/busy; bit 12 = 1 for clause-22 access (0 means clause-45); bits 11:10 opcode, 01 write and 10 read; bits 9:5 sub-device; bits 4:0 register. Reading the command register returns the busy flag in bit 15 and the stored bits 14:0.
- R5: A command written with bit 15 set and a valid clause-22 opcode makes bit 15 read back as 1 for exactly BUSY_CYCLES cycles after the accepting edge (default 4). After that it reads 0.
- R6: An indirect write stores the data register value, as held when the command was accepted, into the addressed sub-device register when busy clears.
- R7: An indirect read places the addressed sub-device register value in the data register, and it is readable from the cycle busy reads 0.
- R8: While busy is set, writes to the command register and to the data register are ignored.
- R9: A command written with a clause-45 mode or with opcode 00 or 11 is stored but starts nothing: busy stays 0 and no internal access takes place.
- R10: With `dual_strap`=1, only `strap[3]` matters. Addresses whose bit 4 equals `strap[3]` are answered, and they reach sub-device address[3:0]. Addresses in the other half give no response.
- R11: `rsp_valid` rises for exactly one cycle, one cycle after each owned transaction. `rsp_rdata` holds the read value for a read and 0 for a write or no response. After reset there is no response and no internal access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_strap | input | 1 | Selects the half-space window |
| strap | input | 4 | Own address bits 4:1 |
| req_valid | input | 1 | Transaction present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Bus device address |
| req_reg | input | 5 | Bus register number |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Owned transaction answered |
| rsp_rdata | output | 16 | Read data of the answered transaction |
| rf_en | output | 1 | Internal register file access strobe |
| rf_we | output | 1 | Internal access is a write |
| rf_dev | output | 5 | Internal sub-device number |
| rf_reg | output | 5 | Internal register number |
| rf_wdata | output | 16 | Internal write data |
| rf_rdata | input | 16 | Internal read data, same-cycle |

## Verification
A busy counter that is off by one shows up within a single polling read of the command register: bit 15 clears a cycle early or late compared with the reference model. A corrupted data register is visible one cycle after the next data read. A wrong internal write target stays hidden until that register is read back, so the bench reads targets back in several windows and compares the whole register image at the end. Wrong window decoding shows on the very next cycle as a missing or extra `rsp_valid` or `rf_en`.

// File: rtl/smi_tgt_pkg.sv
package smi_tgt_pkg;

    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 16;
    localparam int STRAP_W = ADDR_W - 1;
    localparam int HALF_W  = ADDR_W - 1;

    localparam int CMD_BUSY_BIT = DATA_W - 1;
    localparam int CMD_C22_BIT  = 12;
    localparam int CMD_OP_LSB   = 10;
    localparam int CMD_DEV_LSB  = 5;
    localparam int CMD_REG_LSB  = 0;

    localparam logic [1:0] OPC_WR = 2'b01;
    localparam logic [1:0] OPC_RD = 2'b10;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [DATA_W-2:0]  cmd_body_t;
    typedef logic [STRAP_W-1:0] strap_t;

    localparam addr_t REG_CMD  = addr_t'(0);
    localparam addr_t REG_DATA = addr_t'(1);

    typedef enum logic [1:0] {
        MODE_SINGLE   = 2'd0,
        MODE_DUAL     = 2'd1,
        MODE_INDIRECT = 2'd2
    } smi_mode_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } int_op_e;

    typedef struct packed {
        logic  valid;
        logic  write;
        addr_t phy;
        addr_t regad;
        word_t wdata;
    } bus_req_t;

    typedef struct packed {
        logic  en;
        logic  we;
        addr_t dev;
        addr_t regad;
        word_t wdata;
    } rf_req_t;

    function automatic smi_mode_e mode_from_strap(input logic dual, input strap_t s);
        if (dual)
            return MODE_DUAL;
        else if (s == '0)
            return MODE_SINGLE;
        else
            return MODE_INDIRECT;
    endfunction

    function automatic int_op_e cmd_op(input word_t w);
        if (!w[CMD_C22_BIT])
            return OP_NONE;
        case (w[CMD_OP_LSB +: 2])
            OPC_WR:  return OP_WR;
            OPC_RD:  return OP_RD;
            default: return OP_NONE;
        endcase
    endfunction

    function automatic addr_t cmd_dev(input cmd_body_t c);
        return c[CMD_DEV_LSB +: ADDR_W];
    endfunction

    function automatic addr_t cmd_reg(input cmd_body_t c);
        return c[CMD_REG_LSB +: ADDR_W];
    endfunction

endpackage

// File: rtl/smi_addr_decode.sv
module smi_addr_decode
    import smi_tgt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      dual_strap,
    input  strap_t    strap,
    input  logic      req_valid,
    input  addr_t     req_phy,
    input  addr_t     req_regad,
    output smi_mode_e mode,
    output logic      hit,
    output addr_t     dev,
    output logic      sel_cmd,
    output logic      sel_data
);

    addr_t own_addr;

    assign mode     = mode_from_strap(dual_strap, strap);
    assign own_addr = {strap, 1'b0};

    always_comb begin
        hit      = 1'b0;
        dev      = req_phy;
        sel_cmd  = 1'b0;
        sel_data = 1'b0;
        case (mode)
            MODE_SINGLE: begin
                hit = req_valid;
            end
            MODE_DUAL: begin
                hit = req_valid && (req_phy[ADDR_W-1] == strap[STRAP_W-1]);
                dev = {1'b0, req_phy[HALF_W-1:0]};
            end
            default: begin
                if (req_valid && (req_phy == own_addr)) begin
                    sel_cmd  = (req_regad == REG_CMD);
                    sel_data = (req_regad == REG_DATA);
                end
                hit = sel_cmd || sel_data;
            end
        endcase
    end

    // R10: a hit in the half-space window never lands outside the lower half of sub-devices
    p_dual_dev_lower_r10: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DUAL && hit) |-> (dev[ADDR_W-1] == 1'b0));

    // R3: the two register selects never overlap
    p_sel_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_cmd, sel_data}));

endmodule

// File: rtl/smi_indirect_engine.sv
module smi_indirect_engine
    import smi_tgt_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
)(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_cmd,
    input  logic      wr_data,
    input  word_t     wdata,
    input  word_t     rf_rdata,
    output logic      busy,
    output cmd_body_t cmd_body,
    output word_t     data_word,
    output rf_req_t   rf_req
);

    localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    cmd_body_t        cmd_q;
    word_t            data_q;
    int_op_e          cur_op;
    logic             fire;
    logic             start_ok;

    assign cur_op   = cmd_op({1'b1, cmd_q});
    assign fire     = busy_q && (cnt_q == '0);
    assign start_ok = wdata[CMD_BUSY_BIT] && (cmd_op(wdata) != OP_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (fire) begin
                busy_q <= 1'b0;
                if (cur_op == OP_RD)
                    data_q <= rf_rdata;
            end else if (busy_q) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (!busy_q) begin
                if (wr_cmd) begin
                    cmd_q <= wdata[DATA_W-2:0];
                    if (start_ok) begin
                        busy_q <= 1'b1;
                        cnt_q  <= CNT_LOAD;
                    end
                end
                if (wr_data)
                    data_q <= wdata;
            end
        end
    end

    always_comb begin
        rf_req.en    = fire;
        rf_req.we    = fire && (cur_op == OP_WR);
        rf_req.dev   = cmd_dev(cmd_q);
        rf_req.regad = cmd_reg(cmd_q);
        rf_req.wdata = data_q;
    end

    assign busy      = busy_q;
    assign cmd_body  = cmd_q;
    assign data_word = data_q;

    // R5: busy holds while the latency counter has not run out
    p_busy_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != '0) |=> busy_q);

    // R5: the internal access strobe is followed by busy clearing
    p_busy_clears_r5: assert property (@(posedge clk) disable iff (rst)
        rf_req.en |=> !busy_q);

    // R8: command and data stay frozen while an access is pending
    p_cmd_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !fire) |=> ($stable(cmd_q) && $stable(data_q)));

    // R9: an invalid command leaves the engine idle
    p_bad_cmd_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && wr_cmd && cmd_op(wdata) == OP_NONE) |=> !busy_q);

    // R6: one internal access per command
    p_single_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        rf_req.en |=> !rf_req.en);

endmodule

// File: rtl/smi_rsp_stage.sv
module smi_rsp_stage
    import smi_tgt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hit,
    input  logic  is_write,
    input  word_t rd_value,
    output logic  rsp_valid,
    output word_t rsp_rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= hit;
            rsp_rdata <= (hit && !is_write) ? rd_value : '0;
        end
    end

endmodule

// File: rtl/strap_smi_target.sv
module strap_smi_target
    import smi_tgt_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                dual_strap,
    input  logic [STRAP_W-1:0]  strap,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_phy,
    input  logic [ADDR_W-1:0]   req_reg,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rf_en,
    output logic                rf_we,
    output logic [ADDR_W-1:0]   rf_dev,
    output logic [ADDR_W-1:0]   rf_reg,
    output logic [DATA_W-1:0]   rf_wdata,
    input  logic [DATA_W-1:0]   rf_rdata
);

    bus_req_t  req;
    smi_mode_e mode;
    logic      hit;
    addr_t     dec_dev;
    logic      sel_cmd;
    logic      sel_data;
    logic      eng_busy;
    cmd_body_t eng_cmd;
    word_t     eng_data;
    rf_req_t   eng_rf;
    rf_req_t   rf_out;
    word_t     rd_value;

    always_comb begin
        req.valid = req_valid;
        req.write = req_write;
        req.phy   = req_phy;
        req.regad = req_reg;
        req.wdata = req_wdata;
    end

    smi_addr_decode u_decode (
        .clk        (clk),
        .rst        (rst),
        .dual_strap (dual_strap),
        .strap      (strap),
        .req_valid  (req.valid),
        .req_phy    (req.phy),
        .req_regad  (req.regad),
        .mode       (mode),
        .hit        (hit),
        .dev        (dec_dev),
        .sel_cmd    (sel_cmd),
        .sel_data   (sel_data)
    );

    smi_indirect_engine #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .wr_cmd    (sel_cmd && req.write),
        .wr_data   (sel_data && req.write),
        .wdata     (req.wdata),
        .rf_rdata  (rf_rdata),
        .busy      (eng_busy),
        .cmd_body  (eng_cmd),
        .data_word (eng_data),
        .rf_req    (eng_rf)
    );

    always_comb begin
        if (mode == MODE_INDIRECT) begin
            rf_out   = eng_rf;
            rd_value = sel_cmd ? {eng_busy, eng_cmd} : eng_data;
        end else begin
            rf_out.en    = hit;
            rf_out.we    = hit && req.write;
            rf_out.dev   = dec_dev;
            rf_out.regad = req.regad;
            rf_out.wdata = req.wdata;
            rd_value     = rf_rdata;
        end
    end

    assign rf_en    = rf_out.en;
    assign rf_we    = rf_out.we;
    assign rf_dev   = rf_out.dev;
    assign rf_reg   = rf_out.regad;
    assign rf_wdata = rf_out.wdata;

    smi_rsp_stage u_rsp (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .is_write  (req.write),
        .rd_value  (rd_value),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // R11: a transaction that is not owned is never answered
    p_silent_unowned_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !hit) |=> !rsp_valid);

    // R11: write responses carry zero data
    p_write_rsp_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> (rsp_rdata == '0));

    // R1: odd bus addresses are never answered in the indirect window
    p_odd_silent_r1: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_INDIRECT && req_valid && req_phy[0]) |=> !rsp_valid);

    // R3: in the indirect window the internal port is quiet unless an access is pending
    p_port_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_INDIRECT && !eng_busy) |-> !rf_en);

endmodule

// File: tb/strap_smi_target_tb_top.sv
module strap_smi_target_tb_top;

    localparam int BUSY = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dual_strap = 1'b0;
    logic [3:0]  strap = 4'd0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = 5'd0;
    logic [4:0]  req_reg = 5'd0;
    logic [15:0] req_wdata = 16'd0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        rf_en, rf_we;
    logic [4:0]  rf_dev, rf_reg;
    logic [15:0] rf_wdata, rf_rdata;

    logic [15:0] tb_mem  [32][32];
    logic [15:0] ref_mem [32][32];

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    string cur_tag = "R11";

    int          m_busy = 0;
    logic [14:0] m_cmd  = '0;
    logic [15:0] m_data = '0;
    logic        e_valid = 1'b0;
    logic [15:0] e_rdata = '0;
    logic        e_rf_en = 1'b0;
    logic        e_rf_we = 1'b0;

    localparam logic [15:0] K_GO  = 16'h8000;
    localparam logic [15:0] K_C22 = 16'h1000;
    localparam logic [15:0] K_WR  = 16'h0400;
    localparam logic [15:0] K_RD  = 16'h0800;

    always #10 clk = ~clk;

    strap_smi_target #(.BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst(rst), .dual_strap(dual_strap), .strap(strap),
        .req_valid(req_valid), .req_write(req_write), .req_phy(req_phy),
        .req_reg(req_reg), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rf_en(rf_en), .rf_we(rf_we), .rf_dev(rf_dev), .rf_reg(rf_reg),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    assign rf_rdata = tb_mem[rf_dev][rf_reg];

    always @(posedge clk)
        if (rf_en && rf_we) tb_mem[rf_dev][rf_reg] <= rf_wdata;

    initial begin
        for (int d = 0; d < 32; d++)
            for (int r = 0; r < 32; r++) begin
                tb_mem[d][r]  = 16'((d * 1000 + r * 37) ^ 16'hA500);
                ref_mem[d][r] = 16'((d * 1000 + r * 37) ^ 16'hA500);
            end
    end

    // Reference model and per-cycle comparison
    always @(posedge clk) begin
        int  md;
        bit  h, cmd_s, data_s, pre_busy;
        int  dv;
        md = dual_strap ? 1 : (strap == 4'd0 ? 0 : 2);
        h = 0; cmd_s = 0; data_s = 0; dv = req_phy;
        if (md == 0) h = req_valid;
        else if (md == 1) begin
            h  = req_valid && (req_phy[4] == strap[3]);
            dv = req_phy % 16;
        end else if (req_valid && req_phy == {strap, 1'b0}) begin
            cmd_s  = (req_reg == 0);
            data_s = (req_reg == 1);
            h      = cmd_s || data_s;
        end
        if (rst) begin
            m_busy = 0; m_cmd = '0; m_data = '0;
            e_valid = 0; e_rdata = '0;
        end else begin
            e_valid = h;
            e_rdata = '0;
            if (h && !req_write) begin
                if (md != 2) e_rdata = ref_mem[dv][req_reg];
                else if (cmd_s) e_rdata = {(m_busy > 0), m_cmd};
                else e_rdata = m_data;
            end
            if (h && req_write && md != 2) ref_mem[dv][req_reg] = req_wdata;
            pre_busy = (m_busy > 0);
            if (m_busy == 1) begin
                if (m_cmd[11:10] == 2'b10) m_data = ref_mem[m_cmd[9:5]][m_cmd[4:0]];
                else ref_mem[m_cmd[9:5]][m_cmd[4:0]] = m_data;
            end
            if (m_busy > 0) m_busy--;
            if (!pre_busy && req_write) begin
                if (cmd_s) begin
                    m_cmd = req_wdata[14:0];
                    if (req_wdata[15] && req_wdata[12] &&
                        (req_wdata[11:10] == 2'b01 || req_wdata[11:10] == 2'b10))
                        m_busy = BUSY;
                end
                if (data_s) m_data = req_wdata;
            end
        end
        if (md == 2) begin
            e_rf_en = !rst && (m_busy == 1);
            e_rf_we = e_rf_en && (m_cmd[11:10] == 2'b01);
        end else begin
            e_rf_en = h;
            e_rf_we = h && req_write;
        end
        #5;
        checks++;
        if (rsp_valid !== e_valid || rsp_rdata !== e_rdata ||
            rf_en !== e_rf_en || rf_we !== e_rf_we) begin
            fails++;
            $display("FAIL %s: rsp_valid=%0b rsp_rdata=%h rf_en=%0b rf_we=%0b expected %0b %h %0b %0b",
                     cur_tag, rsp_valid, rsp_rdata, rf_en, rf_we, e_valid, e_rdata, e_rf_en, e_rf_we);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic bus_op(input logic w, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_phy = phy; req_reg = rg; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = 16'd0;
    endtask

    task automatic apply_reset(input logic dual, input logic [3:0] s);
        @(negedge clk);
        rst = 1'b1; dual_strap = dual; strap = s;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic poll_cmd(input logic [4:0] own, input int n);
        for (int i = 0; i < n; i++) bus_op(1'b0, own, 5'd0, 16'd0);
    endtask

    initial begin
        int mism;
        // Reset state
        cur_tag = "R11 reset";
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Single-device window
        cur_tag = "R2";
        bus_op(0, 5'd0, 5'd0, 0);
        bus_op(0, 5'd5, 5'd7, 0);
        bus_op(0, 5'd31, 5'd31, 0);
        bus_op(1, 5'd7, 5'd3, 16'hC0DE);
        bus_op(0, 5'd7, 5'd3, 0);
        cur_tag = "R11";
        bus_op(1, 5'd9, 5'd1, 16'h7777);
        bus_op(0, 5'd9, 5'd1, 0);

        // Indirect window, own address 10
        apply_reset(1'b0, 4'b0101);
        cur_tag = "R1";
        bus_op(0, 5'd11, 5'd0, 0);
        bus_op(0, 5'd12, 5'd0, 0);
        bus_op(1, 5'd11, 5'd1, 16'hDEAD);
        bus_op(0, 5'd10, 5'd1, 0);
        cur_tag = "R3";
        bus_op(0, 5'd10, 5'd2, 0);
        bus_op(1, 5'd10, 5'd5, 16'hBEEF);
        bus_op(0, 5'd10, 5'd1, 0);
        cur_tag = "R4";
        bus_op(1, 5'd10, 5'd0, 16'h0123);
        bus_op(0, 5'd10, 5'd0, 0);
        cur_tag = "R6";
        bus_op(1, 5'd10, 5'd1, 16'h5A5A);
        bus_op(1, 5'd10, 5'd0, K_GO | K_C22 | K_WR | (16'd3 << 5) | 16'd9);
        cur_tag = "R5";
        poll_cmd(5'd10, 4);
        cur_tag = "R7";
        bus_op(1, 5'd10, 5'd0, K_GO | K_C22 | K_RD | (16'd3 << 5) | 16'd9);
        poll_cmd(5'd10, 3);
        bus_op(0, 5'd10, 5'd1, 0);
        bus_op(1, 5'd10, 5'd0, K_GO | K_C22 | K_RD | (16'd7 << 5) | 16'd30);
        @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk);
        bus_op(0, 5'd10, 5'd1, 0);
        cur_tag = "R8";
        bus_op(1, 5'd10, 5'd0, K_GO | K_C22 | K_RD | (16'd1 << 5) | 16'd2);
        bus_op(1, 5'd10, 5'd0, K_GO | K_C22 | K_WR | (16'd4 << 5) | 16'd4);
        bus_op(1, 5'd10, 5'd1, 16'h1111);
        poll_cmd(5'd10, 3);
        bus_op(0, 5'd10, 5'd1, 0);
        bus_op(1, 5'd10, 5'd0, K_GO | K_C22 | K_RD | (16'd4 << 5) | 16'd4);
        poll_cmd(5'd10, 3);
        bus_op(0, 5'd10, 5'd1, 0);
        cur_tag = "R9";
        bus_op(1, 5'd10, 5'd0, K_GO | K_RD | (16'd2 << 5) | 16'd2);
        bus_op(0, 5'd10, 5'd0, 0);
        bus_op(1, 5'd10, 5'd0, K_GO | K_C22 | 16'h0C00 | 16'd6);
        bus_op(0, 5'd10, 5'd0, 0);
        bus_op(1, 5'd10, 5'd0, K_GO | K_C22 | 16'd6);
        bus_op(0, 5'd10, 5'd0, 0);
        bus_op(0, 5'd10, 5'd1, 0);

        // Half-space window, upper half
        apply_reset(1'b1, 4'b1011);
        cur_tag = "R10";
        bus_op(0, 5'd18, 5'd4, 0);
        bus_op(1, 5'd20, 5'd1, 16'h4242);
        bus_op(0, 5'd20, 5'd1, 0);
        bus_op(0, 5'd3, 5'd1, 0);
        bus_op(1, 5'd4, 5'd1, 16'h9999);
        bus_op(0, 5'd31, 5'd31, 0);
        bus_op(0, 5'd22, 5'd0, 0);

        // Half-space window, lower half
        apply_reset(1'b1, 4'b0110);
        bus_op(0, 5'd5, 5'd5, 0);
        bus_op(0, 5'd21, 5'd5, 0);
        bus_op(1, 5'd0, 5'd0, 16'h0F0F);
        bus_op(0, 5'd0, 5'd0, 0);
        repeat (3) @(negedge clk);

        // Whole register image
        mism = 0;
        for (int d = 0; d < 32; d++)
            for (int r = 0; r < 32; r++)
                if (tb_mem[d][r] !== ref_mem[d][r]) mism++;
        checks++;
        if (mism != 0) begin
            fails++;
            $display("FAIL R6 image: mismatching entries=%0d expected 0", mism);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule